// File: doc/BRIEF.md
# Power Rail Sequencing Supervisor

This block supervises a set of independently switched power domains on a board. A soft power-on request brings the domains up one at a time in a fixed order set by a parameter. Each domain must report power-good before the next one is enabled. A soft power-off request takes them down in the reverse order, with a fixed pause between steps.

The block also watches for faults and reacts to each kind differently. A domain that loses power-good after it was seen good, a voltage-out-of-window flag or an over-temperature flag removes every enable at once. The block then holds a fault code until a clear input is pulsed. Loss of input power is handled more gently. The block raises a power-fail warning for a fixed interval, so the system can save volatile state, and then runs the ordered shutdown.

Every input is asynchronous and passes through a two-stage synchronizer before the control logic uses it. All outputs are registered.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: After reset, all rail enables, the warning output and the running output are low, and the fault class reads 0.
- R2: A rising power-on request in the idle state enables rails one per step. The order is taken from slot 0 upward of `RAIL_ORDER`, where slot k is the rail index in bits [k*IDX_W +: IDX_W]; the default order is 2, 0, 3, 1. The next rail is enabled only after the previous rail's power-good has been seen. `running` goes high once every rail is up.
- R3: If an enabled rail's power-good is not seen within `PG_TIMEOUT` cycles of its enable, all enables drop and the fault class becomes 2, with `fault_rail` naming that rail.
- R4: A rising power-off request while running clears `running` and disables rails in the reverse of the power-up order, spaced `STEP_DELAY` cycles apart. No fault is recorded, and a later power-on works again.
- R5: If the power-good of a rail already seen good goes low, every enable drops together. The fault class becomes 1, and `fault_rail` gives the lowest-numbered failing rail.
- R6: A high voltage-out-of-window flag while the rails are active drops every enable together, with fault class 3 and `fault_rail` 0.
- R7: A high over-temperature flag while the rails are active drops every enable together, with fault class 4 and `fault_rail` 0.
- R8: Loss of input power while powering up or running raises `pfail_warn` for exactly `WARN_HOLD` cycles while every enable is held. The first rail is disabled in the same cycle that the warning falls. The ordered shutdown of R4 follows, with no fault recorded.
- R9: While a fault is latched, power-on requests are ignored and all enables stay low. A pulse on `fault_clear` returns the fault class to 0 and allows a new power-up.
- R10: The power-good input of a rail that is not enabled has no effect. Toggling it while idle records no fault and enables nothing.
- R11: Every input takes effect on the third rising clock edge after it changes: two synchronizer stages, then the registered control logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Soft power-on request, acts on its rising edge |
| pwr_off_req | input | 1 | Soft power-off request, acts on its rising edge |
| fault_clear | input | 1 | Clears a latched fault |
| rail_pgood | input | N_RAILS | Power-good from each rail, bit i for rail i |
| volt_bad | input | 1 | A monitored voltage is outside its window |
| temp_hot | input | 1 | Over-temperature indication |
| input_ok | input | 1 | Input power present |
| rail_en | output | N_RAILS | Enable to each rail, bit i for rail i |
| pfail_warn | output | 1 | Timed power-fail warning |
| fault_class | output | 3 | 0 none, 1 power-good lost, 2 power-good timeout, 3 voltage, 4 temperature |
| fault_rail | output | IDX_W | Rail index tied to the fault |
| running | output | 1 | All rails up and no shutdown in progress |

## Verification
Any result caused by a bench input change appears on the third rising edge after that change. The bench drives on falling edges and samples on the falling edge after that third rising edge. It also checks on the falling edge one cycle earlier that nothing has moved yet.

Timed results are measured against the cycle in which the bench model saw the related enable change. A timeout fault is due `PG_TIMEOUT` cycles after the enable of the stalled rail. Shutdown steps are due `STEP_DELAY` cycles apart. The warning lasts `WARN_HOLD` cycles. A cycle counter in the bench rail model checks these intervals exactly.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_UP    = 3'd1,
    ST_ON    = 3'd2,
    ST_WARN  = 3'd3,
    ST_DOWN  = 3'd4,
    ST_FAULT = 3'd5
  } pss_state_t;

  typedef enum logic [2:0] {
    FC_NONE       = 3'd0,
    FC_PG_DROP    = 3'd1,
    FC_PG_TIMEOUT = 3'd2,
    FC_VOLT       = 3'd3,
    FC_TEMP       = 3'd4
  } pss_fault_t;

  typedef enum logic [1:0] {
    EN_HOLD = 2'd0,
    EN_SET  = 2'd1,
    EN_CLR  = 2'd2,
    EN_KILL = 2'd3
  } pss_en_op_t;

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pss_order_map.sv
module pss_order_map #(
  parameter int                      N_RAILS    = 4,
  parameter int                      IDX_W      = 2,
  parameter logic [N_RAILS*IDX_W-1:0] RAIL_ORDER = '0
) (
  input  logic [IDX_W-1:0] slot,
  output logic [IDX_W-1:0] rail_idx
);

  localparam logic [N_RAILS*IDX_W-1:0] ORD = RAIL_ORDER;

  always_comb begin
    rail_idx = '0;
    for (int k = 0; k < N_RAILS; k++) begin
      if (slot == IDX_W'(k)) rail_idx = ORD[k*IDX_W +: IDX_W];
    end
  end

endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
  import pss_pkg::*;
#(
  parameter int                      N_RAILS    = 4,
  parameter int                      IDX_W      = (N_RAILS > 1) ? $clog2(N_RAILS) : 1,
  parameter logic [N_RAILS*IDX_W-1:0] RAIL_ORDER = 8'h72,
  parameter int                      TIMER_W    = 16,
  parameter int                      PG_TIMEOUT = 64,
  parameter int                      STEP_DELAY = 8,
  parameter int                      WARN_HOLD  = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_on_req,
  input  logic               pwr_off_req,
  input  logic               fault_clear,
  input  logic [N_RAILS-1:0] rail_pgood,
  input  logic               volt_bad,
  input  logic               temp_hot,
  input  logic               input_ok,
  output logic [N_RAILS-1:0] rail_en,
  output logic               pfail_warn,
  output logic [2:0]         fault_class,
  output logic [IDX_W-1:0]   fault_rail,
  output logic               running
);

  localparam int                 SYNC_W    = N_RAILS + 6;
  localparam logic [IDX_W-1:0]   LAST_SLOT = IDX_W'(N_RAILS - 1);
  localparam logic [TIMER_W-1:0] T_PG      = TIMER_W'(PG_TIMEOUT - 1);
  localparam logic [TIMER_W-1:0] T_STEP    = TIMER_W'(STEP_DELAY - 1);
  localparam logic [TIMER_W-1:0] T_WARN    = TIMER_W'(WARN_HOLD - 1);

  // ---------------------------------------------------------------
  // Input synchronization
  // ---------------------------------------------------------------
  logic [SYNC_W-1:0]  sync_in, sync_out;
  logic               on_s, off_s, clr_s, volt_s, temp_s, inok_s;
  logic [N_RAILS-1:0] pg_s;

  assign sync_in = {rail_pgood, input_ok, temp_hot, volt_bad,
                    fault_clear, pwr_off_req, pwr_on_req};

  pss_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (sync_out)
  );

  assign on_s   = sync_out[0];
  assign off_s  = sync_out[1];
  assign clr_s  = sync_out[2];
  assign volt_s = sync_out[3];
  assign temp_s = sync_out[4];
  assign inok_s = sync_out[5];
  assign pg_s   = sync_out[SYNC_W-1:6];

  // ---------------------------------------------------------------
  // State registers
  // ---------------------------------------------------------------
  pss_state_t         state_q, state_d;
  pss_fault_t         fclass_q, fclass_d;
  pss_en_op_t         en_op;
  logic [IDX_W-1:0]   slot_q, slot_d;
  logic [IDX_W-1:0]   frail_q, frail_d;
  logic [N_RAILS-1:0] en_q, en_d;
  logic [N_RAILS-1:0] seen_q, seen_d;
  logic               warn_q, run_q;
  logic               on_prev_q, off_prev_q;

  logic               on_edge, off_edge;
  logic [IDX_W-1:0]   cur_idx, nxt_idx;
  logic [N_RAILS-1:0] nxt_onehot;
  logic               pg_cur;
  logic [N_RAILS-1:0] drop_vec;
  logic               drop_any;
  logic [IDX_W-1:0]   drop_idx;
  logic               active;

  logic               tmr_load, tmr_dec, tmr_zero;
  logic [TIMER_W-1:0] tmr_val;

  assign on_edge  = on_s & ~on_prev_q;
  assign off_edge = off_s & ~off_prev_q;

  // ---------------------------------------------------------------
  // Order lookup: current slot and next slot
  // ---------------------------------------------------------------
  pss_order_map #(.N_RAILS(N_RAILS), .IDX_W(IDX_W), .RAIL_ORDER(RAIL_ORDER)) u_map_cur (
    .slot     (slot_q),
    .rail_idx (cur_idx)
  );

  pss_order_map #(.N_RAILS(N_RAILS), .IDX_W(IDX_W), .RAIL_ORDER(RAIL_ORDER)) u_map_nxt (
    .slot     (slot_d),
    .rail_idx (nxt_idx)
  );

  genvar r;
  generate
    for (r = 0; r < N_RAILS; r++) begin : g_dec
      assign nxt_onehot[r] = (nxt_idx == IDX_W'(r));
    end
  endgenerate

  assign pg_cur = pg_s[cur_idx];

  // ---------------------------------------------------------------
  // Fault detection: only rails that are enabled and already seen good
  // ---------------------------------------------------------------
  assign drop_vec = seen_q & en_q & ~pg_s;
  assign drop_any = |drop_vec;

  always_comb begin
    drop_idx = '0;
    for (int i = N_RAILS - 1; i >= 0; i--) begin
      if (drop_vec[i]) drop_idx = IDX_W'(i);
    end
  end

  assign active = (state_q == ST_UP) || (state_q == ST_ON) ||
                  (state_q == ST_WARN) || (state_q == ST_DOWN);

  // ---------------------------------------------------------------
  // Shared step timer
  // ---------------------------------------------------------------
  pss_timer #(.W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  // ---------------------------------------------------------------
  // Sequencing control
  // ---------------------------------------------------------------
  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    fclass_d = fclass_q;
    frail_d  = frail_q;
    en_op    = EN_HOLD;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;

    if (active && (drop_any || volt_s || temp_s)) begin
      state_d = ST_FAULT;
      en_op   = EN_KILL;
      if (drop_any) begin
        fclass_d = FC_PG_DROP;
        frail_d  = drop_idx;
      end else if (volt_s) begin
        fclass_d = FC_VOLT;
        frail_d  = '0;
      end else begin
        fclass_d = FC_TEMP;
        frail_d  = '0;
      end
    end else begin
      case (state_q)
        ST_OFF: begin
          if (on_edge) begin
            state_d  = ST_UP;
            slot_d   = '0;
            en_op    = EN_SET;
            tmr_load = 1'b1;
            tmr_val  = T_PG;
          end
        end
        ST_UP: begin
          if (!inok_s) begin
            state_d  = ST_WARN;
            tmr_load = 1'b1;
            tmr_val  = T_WARN;
          end else if (pg_cur) begin
            if (slot_q == LAST_SLOT) begin
              state_d = ST_ON;
            end else begin
              slot_d   = slot_q + 1'b1;
              en_op    = EN_SET;
              tmr_load = 1'b1;
              tmr_val  = T_PG;
            end
          end else if (tmr_zero) begin
            state_d  = ST_FAULT;
            en_op    = EN_KILL;
            fclass_d = FC_PG_TIMEOUT;
            frail_d  = cur_idx;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        ST_ON: begin
          if (!inok_s) begin
            state_d  = ST_WARN;
            tmr_load = 1'b1;
            tmr_val  = T_WARN;
          end else if (off_edge) begin
            state_d  = ST_DOWN;
            en_op    = EN_CLR;
            tmr_load = 1'b1;
            tmr_val  = T_STEP;
          end
        end
        ST_WARN: begin
          if (tmr_zero) begin
            state_d  = ST_DOWN;
            en_op    = EN_CLR;
            tmr_load = 1'b1;
            tmr_val  = T_STEP;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        ST_DOWN: begin
          if (tmr_zero) begin
            if (slot_q == '0) begin
              state_d = ST_OFF;
            end else begin
              slot_d   = slot_q - 1'b1;
              en_op    = EN_CLR;
              tmr_load = 1'b1;
              tmr_val  = T_STEP;
            end
          end else begin
            tmr_dec = 1'b1;
          end
        end
        ST_FAULT: begin
          if (clr_s) begin
            state_d  = ST_OFF;
            fclass_d = FC_NONE;
            frail_d  = '0;
          end
        end
        default: begin
          state_d = ST_FAULT;
          en_op   = EN_KILL;
        end
      endcase
    end
  end

  always_comb begin
    case (en_op)
      EN_SET:  en_d = en_q | nxt_onehot;
      EN_CLR:  en_d = en_q & ~nxt_onehot;
      EN_KILL: en_d = '0;
      default: en_d = en_q;
    endcase
  end

  assign seen_d = (seen_q | (en_q & pg_s)) & en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      slot_q     <= '0;
      fclass_q   <= FC_NONE;
      frail_q    <= '0;
      en_q       <= '0;
      seen_q     <= '0;
      warn_q     <= 1'b0;
      run_q      <= 1'b0;
      on_prev_q  <= 1'b0;
      off_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      slot_q     <= slot_d;
      fclass_q   <= fclass_d;
      frail_q    <= frail_d;
      en_q       <= en_d;
      seen_q     <= seen_d;
      warn_q     <= (state_d == ST_WARN);
      run_q      <= (state_d == ST_ON);
      on_prev_q  <= on_s;
      off_prev_q <= off_s;
    end
  end

  assign rail_en     = en_q;
  assign pfail_warn  = warn_q;
  assign fault_class = fclass_q;
  assign fault_rail  = frail_q;
  assign running     = run_q;

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int N_RAILS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N_RAILS-1:0] rail_en,
  input logic               pfail_warn,
  input logic [2:0]         fault_class,
  input logic               running
);

  AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (fault_class != 3'd0) |-> (rail_en == '0));                          // R5

  AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    running |-> (rail_en == '1));                                        // R2

  AST_ONE_RAIL_UP: assert property (@(posedge clk) disable iff (rst)
    $countones(rail_en & ~$past(rail_en)) <= 1);                         // R2

  AST_ONE_RAIL_DOWN: assert property (@(posedge clk) disable iff (rst)
    (fault_class == 3'd0) |-> ($countones($past(rail_en) & ~rail_en) <= 1)); // R4

  AST_WARN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    pfail_warn |-> (fault_class == 3'd0 && !running));                   // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault_class != 3'd0) |=> (fault_class == $past(fault_class) || fault_class == 3'd0)); // R9

  AST_FAULT_BLOCKS_ON: assert property (@(posedge clk) disable iff (rst)
    (fault_class != 3'd0) |=> (rail_en == '0));                          // R9

endmodule

bind pwr_seq_supervisor pss_checker #(.N_RAILS(N_RAILS)) u_pss_checker (
  .clk         (clk),
  .rst         (rst),
  .rail_en     (rail_en),
  .pfail_warn  (pfail_warn),
  .fault_class (fault_class),
  .running     (running)
);

// File: tb/pwr_seq_supervisor_bench.sv
`timescale 1ns/1ps
module pwr_seq_supervisor_bench;

  localparam int N    = 4;
  localparam int IW   = 2;
  localparam int PGT  = 64;
  localparam int STEP = 8;
  localparam int WH   = 20;
  localparam int ORD [4] = '{2, 0, 3, 1};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          on_req = 1'b0, off_req = 1'b0, clr = 1'b0;
  logic          volt = 1'b0, temp = 1'b0, inok = 1'b1;
  logic [N-1:0]  ready = '0, kill = '0, stuck = '0, force_hi = '0;
  logic [N-1:0]  pgood;
  logic [N-1:0]  rail_en;
  logic          warn, running;
  logic [2:0]    fclass;
  logic [IW-1:0] frail;

  int checks = 0, failures = 0;
  int cyc = 0;
  int on_log [16];
  int on_cyc [16];
  int n_on = 0;
  int off_log [16];
  int off_cyc [16];
  int n_off = 0;

  always #2.5 clk = ~clk;

  assign pgood = (ready & ~kill & ~stuck) | force_hi;

  pwr_seq_supervisor u_pwr_seq_supervisor (
    .clk(clk), .rst(rst), .pwr_on_req(on_req), .pwr_off_req(off_req),
    .fault_clear(clr), .rail_pgood(pgood), .volt_bad(volt), .temp_hot(temp),
    .input_ok(inok), .rail_en(rail_en), .pfail_warn(warn),
    .fault_class(fclass), .fault_rail(frail), .running(running)
  );

  // Rail model: power-good follows an enable after one cycle; logs edges.
  initial begin
    logic [N-1:0] prev = '0;
    logic [N-1:0] d1 = '0;
    forever begin
      @(negedge clk);
      cyc++;
      ready = d1 & rail_en;
      d1 = rail_en;
      for (int i = 0; i < N; i++) begin
        if (rail_en[i] && !prev[i] && n_on < 16) begin
          on_log[n_on] = i; on_cyc[n_on] = cyc; n_on++;
        end
        if (!rail_en[i] && prev[i] && n_off < 16) begin
          off_log[n_off] = i; off_cyc[n_off] = cyc; n_off++;
        end
      end
      prev = rail_en;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    repeat (3) @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic power_up();
    n_on = 0; n_off = 0;
    pulse(on_req);
    for (int t = 0; t < 400 && !running; t++) @(negedge clk);
  endtask

  task automatic do_clear();
    pulse(clr);
    repeat (4) @(negedge clk);
  endtask

  // Fault vectors: {kind[1:0], rail[1:0], exp_class[2:0], exp_rail[1:0]}
  // kind 0 = power-good loss on rail, 1 = voltage flag, 2 = temperature flag
  localparam logic [8:0] VEC [5] = '{
    {2'd0, 2'd2, 3'd1, 2'd2},
    {2'd0, 2'd1, 3'd1, 2'd1},
    {2'd1, 2'd0, 3'd3, 2'd0},
    {2'd2, 2'd0, 3'd4, 2'd0},
    {2'd0, 2'd0, 3'd1, 2'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rail_en == 0, "R1", "rail_en", int'(rail_en), 0);
    check(!warn && !running, "R1", "warn/running", int'({warn, running}), 0);
    check(fclass == 0, "R1", "fault_class", int'(fclass), 0);

    // R10: power-good of disabled rails ignored
    @(negedge clk); force_hi = 4'b1010;
    repeat (6) @(negedge clk); force_hi = '0;
    repeat (6) @(negedge clk);
    check(fclass == 0 && rail_en == 0, "R10", "class/en after idle pgood toggle",
          int'({fclass, rail_en}), 0);

    // R2 ordered power-up
    power_up();
    check(running == 1, "R2", "running", int'(running), 1);
    check(n_on == 4, "R2", "enable count", n_on, 4);
    for (int k = 0; k < 4; k++)
      check(on_log[k] == ORD[k], "R2", "enable order", on_log[k], ORD[k]);
    for (int k = 1; k < 4; k++)
      check(on_cyc[k] > on_cyc[k-1] + 1, "R2", "waits for pgood",
            on_cyc[k] - on_cyc[k-1], 4);

    // R4 ordered power-off
    n_off = 0;
    pulse(off_req);
    for (int t = 0; t < 200 && rail_en != 0; t++) @(negedge clk);
    check(!running && fclass == 0, "R4", "running/class", int'({running, fclass}), 0);
    check(n_off == 4, "R4", "disable count", n_off, 4);
    for (int k = 0; k < 4; k++)
      check(off_log[k] == ORD[3-k], "R4", "disable order", off_log[k], ORD[3-k]);
    for (int k = 1; k < 4; k++)
      check(off_cyc[k] - off_cyc[k-1] == STEP, "R4", "step spacing",
            off_cyc[k] - off_cyc[k-1], STEP);
    repeat (STEP + 2) @(negedge clk);

    // Vector table: immediate shutdown faults (R5, R6, R7, R11)
    for (int v = 0; v < 5; v++) begin
      logic [1:0] kind, rl;
      logic [2:0] ecls;
      logic [1:0] erl;
      {kind, rl, ecls, erl} = VEC[v];
      power_up();
      check(running == 1, "R2", "vector power-up", int'(running), 1);
      if (kind == 2'd0) kill[rl] = 1'b1;
      else if (kind == 2'd1) volt = 1'b1;
      else temp = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(rail_en == 4'hF, "R11", "not yet acted after two edges", int'(rail_en), 15);
      @(posedge clk);
      @(negedge clk);
      check(rail_en == 0, ecls == 1 ? "R5" : (ecls == 3 ? "R6" : "R7"),
            "all enables cut", int'(rail_en), 0);
      check(fclass == ecls, ecls == 1 ? "R5" : (ecls == 3 ? "R6" : "R7"),
            "fault class", int'(fclass), int'(ecls));
      check(frail == erl, "R5", "fault rail", int'(frail), int'(erl));
      kill = '0; volt = 1'b0; temp = 1'b0;
      do_clear();
      check(fclass == 0, "R9", "class after clear", int'(fclass), 0);
    end

    // R8 input power loss
    power_up();
    n_off = 0;
    @(negedge clk); inok = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(warn == 1 && rail_en == 4'hF, "R8", "warning with rails held",
          int'({warn, rail_en}), 31);
    begin
      int wl = 0;
      while (warn && wl < 1000) begin wl++; @(negedge clk); end
      check(wl == WH, "R8", "warning length", wl, WH);
      check(rail_en == (4'hF & ~(4'b1 << ORD[3])), "R8", "first rail off as warning ends",
            int'(rail_en), int'(4'hF & ~(4'b1 << ORD[3])));
    end
    for (int t = 0; t < 200 && rail_en != 0; t++) @(negedge clk);
    check(n_off == 4 && fclass == 0, "R8", "ordered shutdown no fault",
          int'({n_off, fclass}), 32);
    for (int k = 0; k < 4; k++)
      check(off_log[k] == ORD[3-k], "R8", "shutdown order", off_log[k], ORD[3-k]);
    inok = 1'b1;
    repeat (STEP + 4) @(negedge clk);

    // R3 power-good timeout on the second rail in the order
    stuck[ORD[1]] = 1'b1;
    n_on = 0;
    pulse(on_req);
    begin
      int t0 = -1, tf = -1;
      for (int t = 0; t < 400 && fclass == 0; t++) @(negedge clk);
      tf = cyc;
      for (int k = 0; k < n_on; k++) if (on_log[k] == ORD[1]) t0 = on_cyc[k];
      check(fclass == 2, "R3", "timeout class", int'(fclass), 2);
      check(frail == ORD[1], "R3", "timeout rail", int'(frail), ORD[1]);
      check(rail_en == 0, "R3", "enables cut", int'(rail_en), 0);
      check(tf - t0 == PGT, "R3", "timeout interval", tf - t0, PGT);
    end
    stuck = '0;

    // R9 power-on ignored while fault latched
    pulse(on_req);
    repeat (10) @(negedge clk);
    check(rail_en == 0 && fclass == 2, "R9", "on ignored in fault",
          int'({fclass, rail_en}), 32);
    do_clear();
    check(fclass == 0, "R9", "cleared", int'(fclass), 0);
    power_up();
    check(running == 1, "R9", "power-up after clear", int'(running), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule